// File: doc/BRIEF.md
# Quarter-Sampled Buck Modulator

This block is the digital pulse-width modulator for one synchronous buck channel. A free-running period counter turns a duty word into complementary high-side and low-side gate commands, with a programmable dead gap at every hand-over between the two switches. When plain fixed-frequency operation is all that is needed, the block does nothing more than that.

With fast correction enabled, the block looks at the output-voltage window comparator four times per switching period, at evenly spaced counts. A low-limit violation means a load step has pulled the output down. The block then asks for high-side conduction up to the end of the current quarter, and never past a maximum duty. A high-limit violation means load has been released. The block then ends any high-side pulse at once and keeps the low side on for the rest of the period. Both reactions take effect within the period in which the violation is seen. Each applied correction is reported by a one-cycle event pulse.

Top module: `qsbuck_mod`

## Requirements
- R1: A period counter counts from 0 to P-1, where P is the period word. The period word, the duty word and the maximum-duty word are captured only when the counter wraps to 0, so a change made mid-period takes effect in the following period. P is at least 8.
- R2: With no correction active, the high side is requested for counts 0 to min(D, Dmax)-1 of each period, where D is the duty word. The resulting high-side pulse lasts min(D, Dmax) minus the dead gap, in clock cycles.
- R3: When fast correction is enabled, the over-limit and under-limit flags are examined only at counts 0, Q, 2Q and 3Q, where Q = P>>2. At every other count they have no effect.
- R4: An under-limit sample at count kQ requests the high side from the next count up to, but not including, min((k+1)Q, Dmax).
- R5: An over-limit sample withdraws the high-side request from the next count until the period ends, so the low side conducts. Any later under-limit samples in that period are ignored.
- R6: When both flags are set at the same sample, the over-limit reaction is applied and no under-limit correction or event occurs.
- R7: Each applied correction raises its own event output (over or under) for exactly one cycle, in the cycle after the sample.
- R8: With fast correction disabled, both flags are ignored and no event is raised.
- R9: Between one gate falling and the other rising, both gates stay low for exactly max(G,1) cycles, where G is the dead-gap word. The two gates are never high together.
- R10: During reset both gates and both event outputs are low. From the first cycle after reset, the low side is on whenever the high side is not requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Switching period in clocks, captured at wrap |
| duty_i | input | CNT_W | High-side request length in clocks, captured at wrap |
| duty_max_i | input | CNT_W | Maximum high-side request count, captured at wrap |
| os_en_i | input | 1 | Enables the four-point window sampling |
| dead_i | input | DEAD_W | Dead gap in clocks (0 acts as 1) |
| ov_i | input | 1 | Output above the upper window limit |
| uv_i | input | 1 | Output below the lower window limit |
| hs_o | output | 1 | High-side gate command |
| ls_o | output | 1 | Low-side gate command |
| ov_evt_o | output | 1 | One-cycle pulse: over-limit correction applied |
| uv_evt_o | output | 1 | One-cycle pulse: under-limit correction applied |

## Verification
The two reactions that can meet in one cycle are the over-limit cut and the under-limit extension. They meet when both flags are set at the same quarter sample. They also interact when an under-limit sample follows a cut later in the same period. The bench raises both flags together on the count-Q sample, and it also raises them one after the other on consecutive samples. It judges each case by the measured high-side pulse width, which must equal the cut length minus the dead gap, and by the event counts: one over-limit event and no under-limit event.

// File: rtl/qsb_pkg.sv
package qsb_pkg;

  typedef enum logic [1:0] {
    CORR_NONE   = 2'd0,
    CORR_EXTEND = 2'd1,
    CORR_CUT    = 2'd2
  } corr_e;

  function automatic logic [31:0] min_u32(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  // dead gap actually applied: a zero setting still gives one clock
  function automatic logic [31:0] dead_cycles(input logic [31:0] d);
    return (d == 32'd0) ? 32'd1 : d;
  endfunction

  // end (exclusive) of the high-side stretch after an under-limit sample in quarter k
  function automatic logic [31:0] quarter_end(input logic [31:0] k, input logic [31:0] q,
                                              input logic [31:0] cap);
    return min_u32((k + 32'd1) * q, cap);
  endfunction

endpackage

// File: rtl/qsb_period_timer.sv
module qsb_period_timer #(
  parameter int CNT_W   = 10,
  parameter int OS_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] duty_max_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic [CNT_W-1:0] quarter_o,
  output logic [CNT_W-1:0] duty_eff_o,
  output logic [CNT_W-1:0] dmax_o
);

  logic [CNT_W-1:0] cnt_q, per_q, duty_q, dmax_q;

  // wrap when the next count would reach the period (also true for a zero period after reset)
  assign last_o     = ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, per_q};
  assign cnt_o      = cnt_q;
  assign quarter_o  = per_q >> OS_LOG2;
  assign duty_eff_o = duty_q;
  assign dmax_o     = dmax_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      dmax_q <= '0;
    end else if (last_o) begin
      cnt_q  <= '0;
      per_q  <= period_i;
      duty_q <= CNT_W'(qsb_pkg::min_u32(32'(duty_i), 32'(duty_max_i)));
      dmax_q <= duty_max_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R1: the counter never leaves the captured period
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0) |-> (cnt_q < per_q));

endmodule

// File: rtl/qsb_window_corrector.sv
module qsb_window_corrector #(
  parameter int CNT_W   = 10,
  parameter int OS_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             last_i,
  input  logic [CNT_W-1:0] quarter_i,
  input  logic [CNT_W-1:0] duty_eff_i,
  input  logic [CNT_W-1:0] dmax_i,
  input  logic             os_en_i,
  input  logic             ov_i,
  input  logic             uv_i,
  output logic             hs_req_o,
  output logic             ov_take_o,
  output logic             uv_take_o,
  output logic             ov_evt_o,
  output logic             uv_evt_o
);

  localparam int NSAMP = 1 << OS_LOG2;

  qsb_pkg::corr_e   corr_q;
  logic [CNT_W-1:0] ext_end_q;
  logic             ov_evt_q, uv_evt_q;

  logic [CNT_W-1:0] samp_pt  [NSAMP];
  logic [CNT_W-1:0] samp_end [NSAMP];
  logic             hit_any;
  logic [CNT_W-1:0] hit_end;
  logic             samp_now;

  for (genvar k = 0; k < NSAMP; k++) begin : g_pts
    assign samp_pt[k]  = CNT_W'(k) * quarter_i;
    assign samp_end[k] = CNT_W'(qsb_pkg::quarter_end(32'(k), 32'(quarter_i), 32'(dmax_i)));
  end

  always_comb begin
    hit_any = 1'b0;
    hit_end = '0;
    for (int i = 0; i < NSAMP; i++) begin
      if (!hit_any && cnt_i == samp_pt[i]) begin
        hit_any = 1'b1;
        hit_end = samp_end[i];
      end
    end
  end

  assign samp_now  = os_en_i && hit_any && !last_i;
  assign ov_take_o = samp_now && ov_i;
  assign uv_take_o = samp_now && uv_i && !ov_i && (corr_q != qsb_pkg::CORR_CUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q    <= qsb_pkg::CORR_NONE;
      ext_end_q <= '0;
      ov_evt_q  <= 1'b0;
      uv_evt_q  <= 1'b0;
    end else begin
      ov_evt_q <= ov_take_o;
      uv_evt_q <= uv_take_o;
      if (last_i) begin
        corr_q <= qsb_pkg::CORR_NONE;
      end else if (ov_take_o) begin
        corr_q <= qsb_pkg::CORR_CUT;
      end else if (uv_take_o) begin
        corr_q    <= qsb_pkg::CORR_EXTEND;
        ext_end_q <= hit_end;
      end
    end
  end

  always_comb begin
    hs_req_o = 1'b0;
    if (corr_q != qsb_pkg::CORR_CUT) begin
      hs_req_o = (cnt_i < duty_eff_i) ||
                 ((corr_q == qsb_pkg::CORR_EXTEND) && (cnt_i < ext_end_q));
    end
  end

  assign ov_evt_o = ov_evt_q;
  assign uv_evt_o = uv_evt_q;

  // R6: never both corrections reported together
  a_r6_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ov_evt_o && uv_evt_o));

  // R8: events only follow a cycle with sampling enabled
  a_r8_evt_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_evt_o || uv_evt_o) |-> $past(os_en_i));

  // R7: an over-limit event lasts one cycle
  a_r7_ov_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_evt_o && quarter_i > 1) |=> !ov_evt_o);

  // R7: an under-limit event lasts one cycle
  a_r7_uv_single: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_evt_o && quarter_i > 1) |=> !uv_evt_o);

endmodule

// File: rtl/qsb_gate_driver.sv
module qsb_gate_driver #(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_req_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              hs_o,
  output logic              ls_o
);

  logic              hs_q, ls_q;
  logic [DEAD_W-1:0] gap_q;
  logic [DEAD_W-1:0] gap_load;

  assign gap_load = DEAD_W'(qsb_pkg::dead_cycles(32'(dead_i)) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      gap_q <= '0;
    end else if (hs_req_i) begin
      if (ls_q) begin
        ls_q  <= 1'b0;
        gap_q <= gap_load;
      end else if (!hs_q) begin
        if (gap_q == '0) hs_q <= 1'b1;
        else             gap_q <= gap_q - 1'b1;
      end
    end else begin
      if (hs_q) begin
        hs_q  <= 1'b0;
        gap_q <= gap_load;
      end else if (!ls_q) begin
        if (gap_q == '0) ls_q <= 1'b1;
        else             gap_q <= gap_q - 1'b1;
      end
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  // R9: switches never conduct together
  a_r9_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));

  // R9: high side only rises after a cycle with the low side off
  a_r9_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> !$past(ls_q));

  // R9: low side only rises after a cycle with the high side off
  a_r9_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> !$past(hs_q));

endmodule

// File: rtl/qsbuck_mod.sv
module qsbuck_mod #(
  parameter int CNT_W   = 10,
  parameter int DEAD_W  = 4,
  parameter int OS_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  duty_i,
  input  logic [CNT_W-1:0]  duty_max_i,
  input  logic              os_en_i,
  input  logic [DEAD_W-1:0] dead_i,
  input  logic              ov_i,
  input  logic              uv_i,
  output logic              hs_o,
  output logic              ls_o,
  output logic              ov_evt_o,
  output logic              uv_evt_o
);

  logic [CNT_W-1:0] cnt_w, quarter_w, duty_eff_w, dmax_w;
  logic             last_w;
  logic             hs_req_w, ov_take_w, uv_take_w;

  qsb_period_timer #(.CNT_W(CNT_W), .OS_LOG2(OS_LOG2)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_i   (period_i),
    .duty_i     (duty_i),
    .duty_max_i (duty_max_i),
    .cnt_o      (cnt_w),
    .last_o     (last_w),
    .quarter_o  (quarter_w),
    .duty_eff_o (duty_eff_w),
    .dmax_o     (dmax_w)
  );

  qsb_window_corrector #(.CNT_W(CNT_W), .OS_LOG2(OS_LOG2)) u_corr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt_w),
    .last_i     (last_w),
    .quarter_i  (quarter_w),
    .duty_eff_i (duty_eff_w),
    .dmax_i     (dmax_w),
    .os_en_i    (os_en_i),
    .ov_i       (ov_i),
    .uv_i       (uv_i),
    .hs_req_o   (hs_req_w),
    .ov_take_o  (ov_take_w),
    .uv_take_o  (uv_take_w),
    .ov_evt_o   (ov_evt_o),
    .uv_evt_o   (uv_evt_o)
  );

  qsb_gate_driver #(.DEAD_W(DEAD_W)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_req_i (hs_req_w),
    .dead_i   (dead_i),
    .hs_o     (hs_o),
    .ls_o     (ls_o)
  );

  // R5: once the cut is reported the high side is off from the next cycle
  a_r5_ov_cuts_hs: assert property (@(posedge clk) disable iff (!rst_n)
    ov_evt_o |=> !hs_o);

  // R5: an over-limit take drops the high-side request in the following cycle
  a_r5_take_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    ov_take_w |=> !hs_req_w);

  // R4: an under-limit take is reported in the following cycle
  a_r4_take_reported: assert property (@(posedge clk) disable iff (!rst_n)
    uv_take_w |=> uv_evt_o);

endmodule

// File: tb/qsbuck_mod_bench.sv
module qsbuck_mod_bench;

  localparam int CW = 10;
  localparam int DW = 4;
  localparam int P  = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] period_i = CW'(P);
  logic [CW-1:0] duty_i = '0;
  logic [CW-1:0] duty_max_i = CW'(90);
  logic          os_en_i = 1'b1;
  logic [DW-1:0] dead_i = DW'(2);
  logic          ov_i = 1'b0;
  logic          uv_i = 1'b0;
  logic          hs_o, ls_o, ov_evt_o, uv_evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qsbuck_mod #(.CNT_W(CW), .DEAD_W(DW), .OS_LOG2(2)) u_qsbuck_mod (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
    .duty_max_i(duty_max_i), .os_en_i(os_en_i), .dead_i(dead_i),
    .ov_i(ov_i), .uv_i(uv_i), .hs_o(hs_o), .ls_o(ls_o),
    .ov_evt_o(ov_evt_o), .uv_evt_o(uv_evt_o)
  );

  // bench-side phase tracking: after the n-th edge out of reset the count is (n-1) mod P
  int edges = 0;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  function automatic int phase();
    return (edges < 1) ? -1 : (edges - 1) % P;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard of expected high-side pulse widths
  int    exp_q[$];
  string tag_q[$];

  int ov_cnt = 0, uv_cnt = 0;
  int ov_ph = -1, uv_ph = -1;
  int overlap_bad = 0, evt_long = 0;
  int run = 0;
  bit ov_prev = 1'b0, uv_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n && edges >= 1) begin
      if (hs_o && ls_o) overlap_bad++;
      if (ov_evt_o) begin ov_cnt++; ov_ph = phase(); if (ov_prev) evt_long++; end
      if (uv_evt_o) begin uv_cnt++; uv_ph = phase(); if (uv_prev) evt_long++; end
      ov_prev = ov_evt_o;
      uv_prev = uv_evt_o;
      if (hs_o) run++;
      else if (run > 0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected high-side pulse", run, 0);
        end else begin
          int w;
          string t;
          w = exp_q.pop_front();
          t = tag_q.pop_front();
          check(run == w, t, run, w);
        end
        run = 0;
      end
    end
  end

  task automatic wait_phase(input int p);
    do @(negedge clk); while (phase() != p);
  endtask

  task automatic push(input int w, input string t);
    if (w >= 0) begin exp_q.push_back(w); tag_q.push_back(t); end
  endtask

  task automatic inject(input int p, input bit ov, input bit uv);
    if (p >= 0) begin
      wait_phase(p);
      ov_i = ov;
      uv_i = uv;
      @(negedge clk);
      ov_i = 1'b0;
      uv_i = 1'b0;
    end
  endtask

  task automatic scen(input string tag, input int d, input int m, input bit en, input int dt,
                      input int p1, input bit ov1, input bit uv1,
                      input int p2, input bit ov2, input bit uv2,
                      input int w1, input int w2, input int eov, input int euv, input int eph);
    int o0, u0;
    wait_phase(95);
    duty_i = CW'(d);
    duty_max_i = CW'(m);
    os_en_i = en;
    dead_i = DW'(dt);
    o0 = ov_cnt;
    u0 = uv_cnt;
    ov_ph = -1;
    uv_ph = -1;
    push(w1, tag);
    push(w2, tag);
    inject(p1, ov1, uv1);
    inject(p2, ov2, uv2);
    wait_phase(93);
    check(ov_cnt - o0 == eov, {tag, " over-limit events"}, ov_cnt - o0, eov);
    check(uv_cnt - u0 == euv, {tag, " under-limit events"}, uv_cnt - u0, euv);
    if (eph >= 0) begin
      int got;
      got = (eov > 0) ? ov_ph : uv_ph;
      check(got == eph, {tag, " R7 event phase"}, got, eph);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!hs_o && !ls_o, "R10 gates low in reset", {hs_o, ls_o}, 0);
    check(!ov_evt_o && !uv_evt_o, "R10 events low in reset", {ov_evt_o, uv_evt_o}, 0);
    rst_n = 1'b1;
    wait_phase(50);
    check(ls_o && !hs_o, "R10 low side on after reset", {hs_o, ls_o}, 1);

    // plain PWM and duty cap
    scen("R2 plain duty 40",        40, 90, 1'b1, 2, -1, 0, 0, -1, 0, 0, 38, -1, 0, 0, -1);
    scen("R1 R2 duty capped at 90", 95, 90, 1'b1, 2, -1, 0, 0, -1, 0, 0, 88, -1, 0, 0, -1);
    // under-limit extension in each quarter
    scen("R4 uv at quarter 0",      10, 90, 1'b1, 2,  0, 0, 1, -1, 0, 0, 23, -1, 0, 1, 1);
    scen("R4 uv at quarter 1",      10, 90, 1'b1, 2, 25, 0, 1, -1, 0, 0,  8, 22, 0, 1, 26);
    scen("R4 uv at quarter 3",      10, 90, 1'b1, 2, 75, 0, 1, -1, 0, 0,  8, 12, 0, 1, 76);
    scen("R4 uv at quarter 2",      60, 90, 1'b1, 2, 50, 0, 1, -1, 0, 0, 73, -1, 0, 1, 51);
    scen("R4 uv capped by max",     10, 60, 1'b1, 2, 50, 0, 1, -1, 0, 0,  8,  7, 0, 1, 51);
    // over-limit cut
    scen("R5 ov at quarter 1",      60, 90, 1'b1, 2, 25, 1, 0, -1, 0, 0, 24, -1, 1, 0, 26);
    scen("R5 ov at quarter 0",      60, 90, 1'b1, 2,  0, 1, 0, -1, 0, 0, -1, -1, 1, 0, 1);
    scen("R6 ov and uv together",   60, 90, 1'b1, 2, 25, 1, 1, -1, 0, 0, 24, -1, 1, 0, 26);
    scen("R5 uv after cut ignored", 60, 90, 1'b1, 2, 25, 1, 0, 50, 0, 1, 24, -1, 1, 0, 26);
    // disabled and off-sample flags
    scen("R8 flags ignored when off", 10, 90, 1'b0, 2, 25, 0, 1, 50, 1, 0, 8, -1, 0, 0, -1);
    scen("R3 off-sample uv ignored",  10, 90, 1'b1, 2, 30, 0, 1, 60, 1, 0, 8, -1, 0, 0, -1);
    // dead gap
    scen("R9 dead 0 acts as 1",     40, 90, 1'b1, 0, -1, 0, 0, -1, 0, 0, 39, -1, 0, 0, -1);
    scen("R9 dead 5",               40, 90, 1'b1, 5, -1, 0, 0, -1, 0, 0, 35, -1, 0, 0, -1);

    // R1: a duty change mid-period waits for the next wrap
    wait_phase(95);
    duty_i = CW'(40);
    dead_i = DW'(2);
    push(38, "R1 duty held this period");
    push(18, "R1 new duty next period");
    wait_phase(5);
    duty_i = CW'(20);
    wait_phase(93);
    wait_phase(93);

    check(exp_q.size() == 0, "R2 all expected pulses seen", exp_q.size(), 0);
    check(overlap_bad == 0, "R9 gates never high together", overlap_bad, 0);
    check(evt_long == 0, "R7 events one cycle long", evt_long, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule